// File: doc/BRIEF.md
# Embedded Operation Status Poller

This block supplies the byte that a host sees when it reads the memory while an automatic byte program or erase is running. When an operation is accepted it records the kind of operation and the value that bit 7 will hold once the operation is complete. It then loads a duration counter for that kind of operation. Until the counter runs out, every read returns a status byte and not the array contents. In the status byte, bit 7 is the complement of the final value and bit 6 changes on every read.

Software learns that the operation has finished in one of two ways. It can read until bit 7 matches the value it wrote, or it can read until bit 6 stops changing. After the counter expires, reads pass the array byte through again. Both host interface modes use the same status reporting, so the block has no mode input. The two durations are parameters given in clock cycles. With a 33 MHz clock, the defaults correspond to about 10 µs for a byte program and 1 s for a block erase.

Top module: `poll_status_gen`

## Requirements
- R1: After reset, rd_data_o is 0x00 and no operation is in progress, so the first read returns array_data_i.
- R2: While a program operation is in progress, bit 7 of each read result is the inverse of bit 7 of the byte that was programmed.
- R3: While an erase operation is in progress, bit 7 of each read result is 0, because the target value is 1.
- R4: While an operation is in progress, bit 6 of the first read is 0 and alternates on each later read.
- R5: While an operation is in progress, bits 5 down to 0 of each read result are 0.
- R6: A program operation reports busy to reads sampled on exactly PROG_CYCLES rising edges, starting with the edge after the one that accepted it. After that, reads return array_data_i.
- R7: An erase operation reports busy to reads sampled on exactly ERASE_CYCLES edges after acceptance. After that, reads return array_data_i.
- R8: op_start_i is ignored while an operation is in progress. The operation kind, the target bit and the end time are all left unchanged.
- R9: The bit 6 toggle returns to 0 when a new operation is accepted.
- R10: rd_data_o changes only on an edge where rd_i is high. Otherwise it holds its last value.
- R11: When no operation is in progress, a read returns array_data_i as it was on the sampling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_start_i | input | 1 | Start strobe for an embedded operation |
| op_erase_i | input | 1 | Operation kind at start: 1 = erase, 0 = byte program |
| op_data_i | input | DATA_W | Byte being programmed, sampled at start |
| rd_i | input | 1 | Read strobe |
| array_data_i | input | DATA_W | Array byte for the current read address |
| rd_data_o | output | DATA_W | Read result, registered |

## Verification
Every result comes from a register. A read strobe sampled on edge N appears on rd_data_o after edge N. An operation accepted on edge E affects reads sampled from edge E+1 through edge E+PROG_CYCLES (or E+ERASE_CYCLES), and the read sampled on the edge after that returns array data. The bench changes inputs on falling edges and checks each read on the next falling edge. It counts reads from the start strobe so that the last busy read and the first array read land on the exact boundary edge. The overlap and toggle-restart scenarios use the same read count, which lets an ignored start or a leftover toggle show up as a wrong value at a known read.

// File: rtl/poll_status_pkg.sv
package poll_status_pkg;
  typedef enum logic {
    OP_PROGRAM = 1'b0,
    OP_ERASE   = 1'b1
  } op_kind_e;
endpackage

// File: rtl/poll_op_timer.sv
module poll_op_timer #(
  parameter int unsigned PROG_CYCLES  = 330,
  parameter int unsigned ERASE_CYCLES = 33_000_000
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  poll_status_pkg::op_kind_e   kind_i,
  output logic                        busy_o,
  output logic                        accept_o
);
  localparam int unsigned MAX_CYC = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] PROG_LOAD  = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  assign accept_o = start_i & ~busy_q;
  assign busy_o   = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      cnt_q  <= (kind_i == poll_status_pkg::OP_ERASE) ? ERASE_LOAD : PROG_LOAD;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  // R6 R7: busy ends only on terminal count
  a_r6_end_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(cnt_q) == '0);
  a_r7_keep_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != '0) |=> busy_q);
  // R8: a start while busy does not reload
  a_r8_no_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/poll_target_reg.sv
module poll_target_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        accept_i,
  input  poll_status_pkg::op_kind_e   kind_i,
  input  logic [DATA_W-1:0]           data_i,
  output logic                        target_o
);
  localparam int unsigned POLL_BIT = DATA_W - 1;

  logic target_q;
  assign target_o = target_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       target_q <= 1'b0;
    else if (accept_i) target_q <= (kind_i == poll_status_pkg::OP_ERASE) ? 1'b1 : data_i[POLL_BIT];
  end

  // R8: target only moves on an accepted start
  a_r8_target_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_i |=> $stable(target_q));
endmodule

// File: rtl/poll_toggle.sv
module poll_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  input  logic busy_i,
  input  logic rd_i,
  output logic tog_o
);
  logic tog_q;
  assign tog_o = tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              tog_q <= 1'b0;
    else if (accept_i)        tog_q <= 1'b0;
    else if (busy_i && rd_i)  tog_q <= ~tog_q;
  end

  a_r4_flip_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && rd_i && !accept_i) |=> tog_q != $past(tog_q));
  a_r9_clear_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> !tog_q);
endmodule

// File: rtl/poll_status_gen.sv
module poll_status_gen #(
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned PROG_CYCLES  = 330,
  parameter int unsigned ERASE_CYCLES = 33_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_start_i,
  input  logic              op_erase_i,
  input  logic [DATA_W-1:0] op_data_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] array_data_i,
  output logic [DATA_W-1:0] rd_data_o
);
  import poll_status_pkg::*;

  localparam int unsigned POLL_BIT = DATA_W - 1;
  localparam int unsigned TOG_BIT  = DATA_W - 2;

  op_kind_e          kind;
  logic              busy, accept, target, tog;
  logic [DATA_W-1:0] status, rd_q;

  assign kind = op_erase_i ? OP_ERASE : OP_PROGRAM;

  poll_op_timer #(
    .PROG_CYCLES (PROG_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (op_start_i),
    .kind_i  (kind),
    .busy_o  (busy),
    .accept_o(accept)
  );

  poll_target_reg #(.DATA_W(DATA_W)) u_target (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .accept_i(accept),
    .kind_i  (kind),
    .data_i  (op_data_i),
    .target_o(target)
  );

  poll_toggle u_toggle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .accept_i(accept),
    .busy_i  (busy),
    .rd_i    (rd_i),
    .tog_o   (tog)
  );

  always_comb begin
    status           = '0;
    status[POLL_BIT] = ~target;
    status[TOG_BIT]  = tog;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rd_q <= '0;
    else if (rd_i) rd_q <= busy ? status : array_data_i;
  end

  assign rd_data_o = rd_q;

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rd_data_o));
  a_r11_pass_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !busy) |=> rd_data_o == $past(array_data_i));
  a_r5_low_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && busy) |=> rd_data_o[TOG_BIT-1:0] == '0);
endmodule

// File: tb/poll_status_gen_tb_top.sv
module poll_status_gen_tb_top;
  localparam int PROG = 8;
  localparam int ERAS = 20;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       op_start_i = 1'b0, op_erase_i = 1'b0, rd_i = 1'b0;
  logic [7:0] op_data_i = '0, array_data_i = '0, rd_data_o;
  int         n_chk = 0, n_err = 0, cyc = 0;

  always #10 clk = ~clk;

  poll_status_gen #(.DATA_W(8), .PROG_CYCLES(PROG), .ERASE_CYCLES(ERAS)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .op_start_i(op_start_i), .op_erase_i(op_erase_i),
    .op_data_i(op_data_i), .rd_i(rd_i), .array_data_i(array_data_i), .rd_data_o(rd_data_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  // one read: strobe for one edge, result checked at the next falling edge
  task automatic do_read(input logic [7:0] arr, output logic [7:0] res);
    rd_i = 1'b1; array_data_i = arr;
    @(negedge clk);
    rd_i = 1'b0;
    res = rd_data_o;
  endtask

  task automatic start_op(input logic erase, input logic [7:0] d);
    op_start_i = 1'b1; op_erase_i = erase; op_data_i = d;
    @(negedge clk);
    op_start_i = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] r;
    check("R1 reset value", rd_data_o, 8'h00);
    do_read(8'h6B, r);
    check("R1 idle after reset", r, 8'h6B);
  endtask

  task automatic t_program(input logic [7:0] d);
    logic [7:0] r;
    start_op(1'b0, d);
    for (int i = 0; i < PROG; i++) begin
      do_read(8'hFF, r);
      check("R2 poll bit", {7'd0, r[7]}, {7'd0, ~d[7]});
      check("R4 toggle", {7'd0, r[6]}, {7'd0, 1'(i % 2)});
      check("R5 low bits", {2'd0, r[5:0]}, 8'h00);
    end
    do_read(8'h3C, r);
    check("R6 end of program", r, 8'h3C);
  endtask

  task automatic t_erase;
    logic [7:0] r;
    start_op(1'b1, 8'h00);
    for (int i = 0; i < ERAS; i++) begin
      do_read(8'hFF, r);
      check("R3 erase status", r, {1'b0, 1'(i % 2), 6'd0});
    end
    do_read(8'hC3, r);
    check("R7 end of erase", r, 8'hC3);
  endtask

  task automatic t_overlap;
    logic [7:0] r;
    start_op(1'b0, 8'h00);
    do_read(8'h11, r); check("R2 overlap pre", r, 8'h80);
    do_read(8'h11, r); check("R4 overlap pre", r, 8'hC0);
    start_op(1'b1, 8'hFF);
    for (int i = 0; i < PROG - 3; i++) begin
      do_read(8'h11, r);
      check("R8 start ignored", r, {1'b1, 1'(i % 2), 6'd0});
    end
    do_read(8'h5E, r);
    check("R8 original end time", r, 8'h5E);
  endtask

  task automatic t_toggle_restart;
    logic [7:0] r;
    start_op(1'b0, 8'h80);
    for (int i = 0; i < 3; i++) do_read(8'h00, r);
    for (int i = 0; i < PROG - 3; i++) @(negedge clk);
    start_op(1'b0, 8'h80);
    do_read(8'h00, r);
    check("R9 toggle cleared", r, 8'h00);
    for (int i = 0; i < PROG - 1; i++) @(negedge clk);
    do_read(8'h77, r);
    check("R11 idle read", r, 8'h77);
  endtask

  task automatic t_hold;
    logic [7:0] r;
    do_read(8'h29, r);
    array_data_i = 8'hD6;
    for (int i = 0; i < 3; i++) @(negedge clk);
    check("R10 hold without read", rd_data_o, 8'h29);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_program(8'h5A);
    t_program(8'hA5);
    t_erase();
    t_overlap();
    t_toggle_restart();
    t_hold();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got %0d cycles expected under 5000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule